// File: doc/BRIEF.md
# Debounced Serial Link Bring-Up Controller

This block walks a point-to-point serial link from power-up to full two-way operation, and it keeps the link there. A frame classifier outside the block reports one indication per frame time, qualified by a frame-valid strobe. The indication is one of fill type 0, fill type 1, data, error or reset. From the sequence of indications the controller moves between three link states: idle/acquiring, lock acknowledged, and synchronized. It presents the current state as a two-bit status word, together with four control lines taken from that word. These lines select which fill frame the local transmitter sends, enable transmit data, switch off the receive frequency detector, and enable the receive output.

The controller filters its inputs so that one corrupted frame cannot move it. A state change needs the same indication on two frames in a row. Two bad frames in a row (error or reset, in any mix) send the link back to the idle state and arm a hold-off. During the hold-off the link stays idle until a run of 128 consecutive clean frames has been seen. Any bad frame during that run starts the run again.

Top module: `link_sync_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller enters the idle state (status 00), clears its frame history and clears the hold-off. The first valid frame after reset cannot cause a transition, because it has no predecessor to pair with.
- R2: `frame_kind` is coded 0 = fill type 0, 1 = fill type 1, 2 = data, 3 = error, 4 = reset. Codes 5 to 7 are treated as error. The status word {`stat1`,`stat0`} is 00 when idle, 10 when lock is acknowledged and 11 when synchronized. The value 01 never appears.
- R3: `fill_sel`, `fd_disable` and `rx_active` always equal `stat1`. `tx_data_en` always equals `stat0`.
- R4: A cycle with `frame_vld` low changes neither the state, the frame history nor the hold-off, whatever `frame_kind` carries.
- R5: A transition happens only on a valid frame whose indication matches the indication of the previous valid frame. Error and reset count as the same indication.
- R6: In the idle state, with no hold-off active, a matching pair of fill type 0 frames or of fill type 1 frames moves the controller to lock acknowledged. A data pair leaves it idle.
- R7: In lock acknowledged, a matching pair of fill type 1 frames or of data frames moves the controller to synchronized. A fill type 0 pair keeps it in lock acknowledged.
- R8: In the synchronized state, fill and data pairs leave the state unchanged.
- R9: A matching pair of bad frames returns the controller to idle from any state and arms the hold-off.
- R10: While the hold-off is armed the controller stays idle. The hold-off clears on the 128th consecutive clean valid frame, and any bad frame restarts the count. Only a later matching fill pair can leave idle, so the earliest exit is on the 129th clean frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one frame indication at most per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_vld | input | 1 | High when `frame_kind` carries a new frame indication |
| frame_kind | input | 3 | Classified frame indication (coding in R2) |
| stat1 | output | 1 | Status bit 1: high in lock acknowledged and synchronized |
| stat0 | output | 1 | Status bit 0: high only in synchronized |
| fill_sel | output | 1 | Transmit fill-frame select (0 = type 0, 1 = type 1) |
| tx_data_en | output | 1 | Transmit parallel data enable |
| fd_disable | output | 1 | Receive frequency-detector disable |
| rx_active | output | 1 | Receive parallel output enable |

## Verification
The hardest condition to reach from the ports is the exact end of the hold-off. To get there the bench must arm the timer with a bad pair and then feed a long clean run. It must break that run partway with a lone error, so that the restart is visible, and then count frames precisely. The bench does this as a directed sequence. It checks that the state is still idle on the 128th clean frame after the restart, and that it moves on the 129th. A further sweep starts from each of the three states and applies every ordered pair of the eight frame codes. The result of every step is compared against an arithmetic model in the bench, which catches single-frame and mismatched-pair leaks.

// File: rtl/lsync_pkg.sv
// Shared types for the link bring-up controller.
// The state enum values are chosen to equal the {stat1,stat0} status word.
package lsync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACK  = 2'b10,
        ST_SYNC = 2'b11
    } lsync_state_e;

    typedef enum logic [1:0] {
        IND_FILL0 = 2'd0,
        IND_FILL1 = 2'd1,
        IND_DATA  = 2'd2,
        IND_BAD   = 2'd3
    } lsync_ind_e;

    localparam logic [2:0] KIND_FILL0 = 3'd0;
    localparam logic [2:0] KIND_FILL1 = 3'd1;
    localparam logic [2:0] KIND_DATA  = 3'd2;

    // Map a raw frame code onto an indication class; error, reset and unused codes are bad
    function automatic lsync_ind_e classify(input logic [2:0] kind);
        case (kind)
            KIND_FILL0: return IND_FILL0;
            KIND_FILL1: return IND_FILL1;
            KIND_DATA:  return IND_DATA;
            default:    return IND_BAD;
        endcase
    endfunction

endpackage

// File: rtl/lsync_debounce.sv
// Frame-pair debouncer.
// Remembers the indication class of the last valid frame and flags when the
// current valid frame carries the same class. Assumes frame_kind is only
// meaningful while frame_vld is high.
module lsync_debounce
    import lsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [2:0] frame_kind,
    output lsync_ind_e cur_ind,
    output logic       pair_ok
);

    logic       prev_seen;
    lsync_ind_e prev_ind;

    // Classify the incoming frame
    assign cur_ind = classify(frame_kind);

    // A pair exists when this valid frame repeats the previous valid frame's class
    assign pair_ok = frame_vld && prev_seen && (prev_ind == cur_ind);

    // Capture history only on valid frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_seen <= 1'b0;
            prev_ind  <= IND_FILL0;
        end else if (frame_vld) begin
            prev_seen <= 1'b1;
            prev_ind  <= cur_ind;
        end
    end

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(prev_ind) && $stable(prev_seen)));

endmodule

// File: rtl/lsync_holdoff.sv
// Error hold-off timer.
// Armed by a debounced bad pair. While armed it counts consecutive clean
// valid frames and clears itself on the HOLD_FRAMES-th one. A bad frame
// restarts the count. Assumes HOLD_FRAMES >= 2.
module lsync_holdoff
    import lsync_pkg::*;
#(
    parameter int HOLD_FRAMES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic       pair_ok,
    input  lsync_ind_e cur_ind,
    output logic       hold_act
);

    localparam int             CNT_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

    logic             cur_bad;
    logic             arm;
    logic [CNT_W-1:0] clean_cnt;

    // Decode trigger conditions
    assign cur_bad = (cur_ind == IND_BAD);
    assign arm     = frame_vld && pair_ok && cur_bad;

    // Arm, count clean frames, restart on bad frames, release on the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_act  <= 1'b0;
            clean_cnt <= '0;
        end else if (frame_vld) begin
            if (arm) begin
                hold_act  <= 1'b1;
                clean_cnt <= '0;
            end else if (hold_act) begin
                if (cur_bad) begin
                    clean_cnt <= '0;
                end else if (clean_cnt == LAST) begin
                    hold_act  <= 1'b0;
                    clean_cnt <= '0;
                end else begin
                    clean_cnt <= clean_cnt + 1'b1;
                end
            end
        end
    end

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_act |-> (clean_cnt == '0));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && cur_bad) |=> (clean_cnt == '0));

endmodule

// File: rtl/lsync_state.sv
// Three-state link state register.
// Advances only on debounced pairs of valid frames. A bad pair always
// returns to idle. Leaving idle is blocked while the hold-off is armed.
module lsync_state
    import lsync_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic         pair_ok,
    input  lsync_ind_e   cur_ind,
    input  logic         hold_act,
    output lsync_state_e state
);

    lsync_state_e state_nx;

    // Next-state selection from the debounced indication
    always_comb begin
        state_nx = state;
        if (frame_vld && pair_ok) begin
            if (cur_ind == IND_BAD) begin
                state_nx = ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (!hold_act && (cur_ind == IND_FILL0 || cur_ind == IND_FILL1))
                                 state_nx = ST_ACK;
                    ST_ACK:  if (cur_ind == IND_FILL1 || cur_ind == IND_DATA)
                                 state_nx = ST_SYNC;
                    ST_SYNC: state_nx = ST_SYNC;
                    default: state_nx = ST_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R4
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(state));

    // R5
    single_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_ok |=> $stable(state));

    // R9
    bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && pair_ok && cur_ind == IND_BAD) |=> (state == ST_IDLE));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> (state == ST_IDLE));

    // R6
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_SYNC));

endmodule

// File: rtl/link_sync_ctrl.sv
// Link bring-up controller top.
// Chains the pair debouncer, the error hold-off timer and the state register.
// The state drives the status word, and the four control lines are taken
// from the status bits. Assumes at most one frame indication per clock.
module link_sync_ctrl
    import lsync_pkg::*;
#(
    parameter int HOLD_FRAMES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [2:0] frame_kind,
    output logic       stat1,
    output logic       stat0,
    output logic       fill_sel,
    output logic       tx_data_en,
    output logic       fd_disable,
    output logic       rx_active
);

    lsync_ind_e   cur_ind;
    logic         pair_ok;
    logic         hold_act;
    lsync_state_e state;

    lsync_debounce u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_kind (frame_kind),
        .cur_ind    (cur_ind),
        .pair_ok    (pair_ok)
    );

    lsync_holdoff #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .pair_ok   (pair_ok),
        .cur_ind   (cur_ind),
        .hold_act  (hold_act)
    );

    lsync_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .pair_ok   (pair_ok),
        .cur_ind   (cur_ind),
        .hold_act  (hold_act),
        .state     (state)
    );

    // Status word is the state encoding itself
    assign {stat1, stat0} = state;

    // Control lines taken from the status bits
    assign fill_sel   = stat1;
    assign fd_disable = stat1;
    assign rx_active  = stat1;
    assign tx_data_en = stat0;

    // R2
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat0 |-> stat1);

    // R9
    drop_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 && frame_vld && pair_ok && cur_ind == IND_BAD) |=> !stat1);

endmodule

// File: tb/tb_link_sync_ctrl.sv
module tb_link_sync_ctrl;

    localparam int HOLD = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [2:0] frame_kind = 3'd0;
    logic       stat1, stat0, fill_sel, tx_data_en, fd_disable, rx_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    int m_state;   // 0 idle, 1 ack, 2 sync
    bit m_pv;
    int m_pc;
    bit m_hold;
    int m_cnt;

    always #4 clk = ~clk;   // 125 MHz

    link_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_kind(frame_kind),
        .stat1(stat1), .stat0(stat0), .fill_sel(fill_sel), .tx_data_en(tx_data_en),
        .fd_disable(fd_disable), .rx_active(rx_active)
    );

    function automatic int cls(input int k);
        return (k <= 2) ? k : 3;
    endfunction

    task automatic model_reset();
        m_state = 0; m_pv = 0; m_pc = 0; m_hold = 0; m_cnt = 0;
    endtask

    task automatic model_step(input int k);
        int  c;
        bit  pair;
        bit  old_hold;
        c        = cls(k);
        pair     = m_pv && (m_pc == c);
        old_hold = m_hold;
        if (pair && c == 3) begin
            m_state = 0; m_hold = 1; m_cnt = 0;
        end else begin
            if (m_hold) begin
                if (c == 3) m_cnt = 0;
                else if (m_cnt == HOLD - 1) begin m_hold = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (pair) begin
                if (m_state == 0 && !old_hold && (c == 0 || c == 1)) m_state = 1;
                else if (m_state == 1 && (c == 1 || c == 2)) m_state = 2;
            end
        end
        m_pv = 1; m_pc = c;
    endtask

    task automatic chk(input string req, input int exp_state);
        logic [5:0] act, exp;
        logic e1, e0;
        e1  = (exp_state != 0);
        e0  = (exp_state == 2);
        exp = {e1, e0, e1, e0, e1, e1};
        act = {stat1, stat0, fill_sel, tx_data_en, fd_disable, rx_active};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic frame(input int k);
        @(negedge clk);
        frame_vld  = 1'b1;
        frame_kind = 3'(k);
        @(negedge clk);
        frame_vld  = 1'b0;
        model_step(k);
    endtask

    task automatic idle_cycles(input int k, input int n);
        frame_vld  = 1'b0;
        frame_kind = 3'(k);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        chk("R1 reset state", 0);

        // R6: fill0 pair -> ack; R7: fill1 pair -> sync
        frame(0); chk("R5 single fill0", 0);
        frame(0); chk("R6 fill0 pair", 1);
        frame(1); chk("R5 single fill1", 1);
        frame(1); chk("R7 fill1 pair", 2);
        frame(0); frame(0); chk("R8 fill0 pair in sync", 2);

        // R1: history cleared by reset
        frame(1);
        do_reset();
        chk("R1 status after reset", 0);
        frame(1); chk("R1 no pair across reset", 0);

        // R4: invalid cycles ignored, history untouched
        do_reset();
        frame(0); frame(0); chk("R6 ack", 1);
        idle_cycles(1, 3); chk("R4 ignored fill1 strobe low", 1);
        idle_cycles(3, 3); chk("R4 ignored error strobe low", 1);
        frame(1); chk("R4 history kept", 1);
        frame(2); chk("R5 mismatched fill1 data", 1);
        frame(2); chk("R7 data pair", 2);

        // R9 and R10: hold-off exact boundary with restart
        frame(3); frame(4); chk("R9 error reset pair from sync", 0);
        for (int i = 0; i < HOLD - 1; i++) frame(0);
        chk("R10 held after 127 clean", 0);
        frame(7); chk("R2 code 7 is error, R10 restart", 0);
        for (int i = 0; i < HOLD - 1; i++) frame(0);
        chk("R10 held after 127 clean post restart", 0);
        frame(0); chk("R10 still idle on 128th clean", 0);
        frame(0); chk("R10 leave on 129th clean", 1);

        // R6: data pair does not leave idle
        do_reset();
        frame(2); frame(2); chk("R6 data pair stays idle", 0);
        frame(5); frame(6); chk("R2 codes 5 6 form bad pair", 0);
        // hold active: fill pair cannot leave
        frame(1); frame(1); chk("R10 fill pair blocked in hold", 0);

        // sweep: each start state, every ordered pair of codes
        for (int s = 0; s < 3; s++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    do_reset();
                    if (s >= 1) begin frame(0); frame(0); end
                    if (s >= 2) begin frame(1); frame(1); end
                    frame(a); chk("R2 R5 R6 R7 R8 R9 sweep first", m_state);
                    frame(b); chk("R2 R3 R5 R6 R7 R8 R9 sweep second", m_state);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule